// File: doc/BRIEF.md
# Parallel-Lane Doppler-Compensating Oscillator and Mixer

This block removes a predicted Doppler offset from a real intermediate-frequency stream that arrives as eight samples per clock (a 1.28 GHz sample rate carried on a 160 MHz clock). One 40-bit phase accumulator serves all eight lanes. Each lane gets its own phase from a fixed multiple of the frequency word, so the eight lanes form eight consecutive sample instants. The accumulator then steps by eight times the frequency word on every clock.

Software loads a sixteen-entry table of predicted frequency words through a plain address/data/write-enable port. On each one-pulse-per-second strobe the block takes the next entry as its new frequency word. The accumulator is never cleared, so the tuning stays phase continuous. Each lane looks up a cosine and sine amplitude from the top ten phase bits and multiplies them with its 8-bit sample. The lane then emits an in-phase and a quadrature product.

Top module: `doppler_nco_mixer`

## Requirements
- R1: After synchronous reset, every output is zero, the accumulator and frequency word are zero, and the read pointer selects entry 0. Until the first strobe, every lane therefore uses phase 0.
- R2: Successive `pps` strobes load table entries 0, 1, 2, … in that order as the frequency word.
- R3: A frequency word loaded by a strobe at clock edge E first applies to the samples presented in the cycle after E, and it applies to all eight lanes at once. The samples presented in the strobe cycle still use the previous word.
- R4: For the samples of a cycle with accumulator value p and frequency word F, lane k (lane 0 in the least significant slice of each bus) uses phase p + k·F. The accumulator advances by 8·F per clock.
- R5: A strobe never resets or jumps the accumulator. It only changes the step applied from the next clock on.
- R6: After entry 15 has been loaded, each further strobe reloads entry 15, including any value written there since.
- R7: The amplitude for a 10-bit phase index a (the top ten accumulator bits) is S(a). Let h = a mod 512 and t = h·(512−h). Then S(a) = ⌊2047·16·t / (5·512² − 4·t)⌋, negated when a ≥ 512. The cosine is S((a+256) mod 1024).
- R8: Each lane outputs I = x·cos and Q = −x·sin as 20-bit two's-complement values, where x is the signed 8-bit sample. The products appear two clock edges after the sample is presented.
- R9: When a table write and a strobe fall in the same cycle and the write targets the entry being loaded, the strobe loads the entry's previous content and the write still takes effect.
- R10: All phase arithmetic wraps modulo 2^40, including frequency words with the top bit set, which act as negative offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pps | input | 1 | One-cycle epoch strobe that loads the next frequency word |
| tbl_we | input | 1 | Predict table write enable |
| tbl_addr | input | 4 | Predict table write address |
| tbl_wdata | input | 40 | Frequency word to store |
| samp_in | input | 64 | Eight signed 8-bit samples, lane 0 in bits 7:0 |
| mix_i | output | 160 | Eight signed 20-bit in-phase products, lane 0 in bits 19:0 |
| mix_q | output | 160 | Eight signed 20-bit quadrature products, lane 0 in bits 19:0 |

## Verification
A table write and an epoch strobe can land in the same cycle. The bench provokes this by writing, in the strobe cycle, a new value into the very entry the strobe is about to load. Its behavioural model applies the read-before-write order of R9. Every later product is judged against that model, so loading the new value instead of the old one shows up as a wrong phase progression on all lanes. A second overlap happens at the strobe itself: the samples of that cycle still use the old step while the next cycle uses the new one, and the cycle-by-cycle comparison checks exactly that boundary.

// File: rtl/dnco_pkg.sv
package dnco_pkg;

  // Quarter-wave sine amplitude for index i of a quarter holding qn steps,
  // using a rational approximation that is exact at 0 and at the peak.
  function automatic int quarter_amp(input int i, input int qn, input int amax);
    longint p;
    longint t;
    p = 2 * longint'(qn);
    t = longint'(i) * (p - longint'(i));
    return int'((longint'(amax) * 16 * t) / (5 * p * p - 4 * t));
  endfunction

endpackage

// File: rtl/dnco_predict_table.sv
module dnco_predict_table #(
  parameter int PHASE_W = 40,
  parameter int DEPTH   = 16,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pps,
  input  logic               we,
  input  logic [PTR_W-1:0]   waddr,
  input  logic [PHASE_W-1:0] wdata,
  output logic [PHASE_W-1:0] freq
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PHASE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   rd_ptr;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      freq   <= '0;
    end else if (pps) begin
      freq <= mem[rd_ptr];
      if (rd_ptr != LAST) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  AST_FREQ_HELD: assert property (@(posedge clk) disable iff (rst)
    !pps |=> $stable(freq)); // R3
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (pps && rd_ptr != LAST) |=> rd_ptr == $past(rd_ptr) + 1'b1); // R2
  AST_PTR_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (pps && rd_ptr == LAST) |=> rd_ptr == LAST); // R6

endmodule

// File: rtl/dnco_phase_gen.sv
module dnco_phase_gen #(
  parameter int PHASE_W = 40,
  parameter int LANES   = 8,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] freq,
  output logic [ADDR_W-1:0]  ph_o [LANES]
);

  localparam int SHIFT = PHASE_W - ADDR_W;

  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] step;

  assign step = freq * PHASE_W'(LANES);

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + step;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PHASE_W-1:0] offs;
    assign offs = freq * PHASE_W'(g);
    always_ff @(posedge clk) begin
      if (rst) ph_o[g] <= '0;
      else     ph_o[g] <= ADDR_W'((acc + offs) >> SHIFT);
    end
  end

  AST_ACC_KEPT: assert property (@(posedge clk) disable iff (rst)
    (freq == '0) |=> $stable(acc)); // R5

  if (LANES > 1) begin : g_chk
    AST_LANES_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      (freq == '0) |=> ph_o[1] == ph_o[0]); // R4
  end

endmodule

// File: rtl/dnco_lane_mixer.sv
module dnco_lane_mixer
  import dnco_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 12,
  parameter int SAMP_W = 8,
  localparam int OUT_W = SAMP_W + AMP_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        ph,
  input  logic signed [SAMP_W-1:0] x,
  output logic signed [OUT_W-1:0]  i_o,
  output logic signed [OUT_W-1:0]  q_o
);

  localparam int QN     = 2 ** (ADDR_W - 2);
  localparam int QIDX_W = ADDR_W - 1;
  localparam int AMP_MX = 2 ** (AMP_W - 1) - 1;

  logic signed [AMP_W-1:0] qrom [QN + 1];

  for (genvar g = 0; g <= QN; g++) begin : g_rom
    assign qrom[g] = AMP_W'(quarter_amp(g, QN, AMP_MX));
  end

  logic [ADDR_W-1:0]       ph_c;
  logic [QIDX_W-1:0]       idx_s, idx_c;
  logic signed [AMP_W-1:0] sin_v, cos_v;

  assign ph_c = ph + ADDR_W'(QN);

  always_comb begin
    idx_s = ph[ADDR_W-2] ? QIDX_W'(QN) - QIDX_W'(ph[ADDR_W-3:0])
                         : QIDX_W'(ph[ADDR_W-3:0]);
    idx_c = ph_c[ADDR_W-2] ? QIDX_W'(QN) - QIDX_W'(ph_c[ADDR_W-3:0])
                           : QIDX_W'(ph_c[ADDR_W-3:0]);
    sin_v = ph[ADDR_W-1]   ? -qrom[idx_s] : qrom[idx_s];
    cos_v = ph_c[ADDR_W-1] ? -qrom[idx_c] : qrom[idx_c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_o <= '0;
      q_o <= '0;
    end else begin
      i_o <= OUT_W'(x) * OUT_W'(cos_v);
      q_o <= -(OUT_W'(x) * OUT_W'(sin_v));
    end
  end

  AST_AMP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (sin_v <= AMP_W'(AMP_MX)) && (sin_v >= -AMP_W'(AMP_MX))); // R7

endmodule

// File: rtl/doppler_nco_mixer.sv
module doppler_nco_mixer #(
  parameter int LANES   = 8,
  parameter int PHASE_W = 40,
  parameter int SAMP_W  = 8,
  parameter int AMP_W   = 12,
  parameter int ADDR_W  = 10,
  parameter int DEPTH   = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int OUT_W  = SAMP_W + AMP_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pps,
  input  logic                     tbl_we,
  input  logic [PTR_W-1:0]         tbl_addr,
  input  logic [PHASE_W-1:0]       tbl_wdata,
  input  logic [LANES*SAMP_W-1:0]  samp_in,
  output logic [LANES*OUT_W-1:0]   mix_i,
  output logic [LANES*OUT_W-1:0]   mix_q
);

  logic [PHASE_W-1:0] freq;
  logic [ADDR_W-1:0]  ph [LANES];

  dnco_predict_table #(.PHASE_W(PHASE_W), .DEPTH(DEPTH)) u_table (
    .clk(clk), .rst(rst), .pps(pps), .we(tbl_we),
    .waddr(tbl_addr), .wdata(tbl_wdata), .freq(freq)
  );

  dnco_phase_gen #(.PHASE_W(PHASE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_phase (
    .clk(clk), .rst(rst), .freq(freq), .ph_o(ph)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_mix
    logic signed [SAMP_W-1:0] x_r;
    logic signed [OUT_W-1:0]  i_w, q_w;

    always_ff @(posedge clk) begin
      if (rst) x_r <= '0;
      else     x_r <= samp_in[g*SAMP_W +: SAMP_W];
    end

    dnco_lane_mixer #(.ADDR_W(ADDR_W), .AMP_W(AMP_W), .SAMP_W(SAMP_W)) u_lane (
      .clk(clk), .rst(rst), .ph(ph[g]), .x(x_r), .i_o(i_w), .q_o(q_w)
    );

    assign mix_i[g*OUT_W +: OUT_W] = i_w;
    assign mix_q[g*OUT_W +: OUT_W] = q_w;
  end

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    (samp_in == '0) |=> ##1 (mix_i == '0 && mix_q == '0)); // R8

endmodule

// File: tb/doppler_nco_mixer_tb.sv
module doppler_nco_mixer_tb;

  localparam int CLK_P = 10;
  localparam int L     = 8;
  localparam int OW    = 20;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pps = 1'b0;
  logic           tbl_we = 1'b0;
  logic [3:0]     tbl_addr = '0;
  logic [39:0]    tbl_wdata = '0;
  logic [L*8-1:0] samp_in = '0;
  logic [L*OW-1:0] mix_i, mix_q;

  always #(CLK_P/2) clk = ~clk;

  doppler_nco_mixer u_dut (
    .clk(clk), .rst(rst), .pps(pps), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .samp_in(samp_in), .mix_i(mix_i), .mix_q(mix_q)
  );

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;

  logic [39:0] m_acc = '0, m_freq = '0;
  logic [39:0] m_tbl [16];
  int          m_ptr = 0;

  logic [L*OW-1:0] q_i [$];
  logic [L*OW-1:0] q_q [$];
  string           q_tag [$];
  string           tag;

  function automatic int bsin(input int a);
    int h;
    longint t, v;
    h = a % 512;
    t = longint'(h) * (512 - h);
    v = (longint'(2047) * 16 * t) / (5 * 512 * 512 - 4 * t);
    return (a >= 512) ? -int'(v) : int'(v);
  endfunction

  function automatic int samp(input int n, input int k);
    return ((n * 37 + k * 53 + (n / 7) * 11) % 256) - 128;
  endfunction

  function automatic logic [39:0] tblv(input int i);
    if (i == 0) return 40'h00_4000_0000;
    if (i == 1) return 40'hFF_F000_0000;
    return 40'(i) * 40'h13_3333_3337 + 40'hA5;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic step(input bit p, input bit we, input int addr, input logic [39:0] d);
    logic [L*OW-1:0] ei, eq;
    pps = p; tbl_we = we; tbl_addr = 4'(addr); tbl_wdata = d;
    for (int k = 0; k < L; k++) begin
      logic [39:0] ph;
      int a, x;
      x = samp(cyc, k);
      samp_in[k*8 +: 8] = 8'(x);
      ph = m_acc + 40'(k) * m_freq;
      a  = int'(ph[39:30]);
      ei[k*OW +: OW] = OW'(x * bsin((a + 256) % 1024));
      eq[k*OW +: OW] = OW'(-(x * bsin(a)));
    end
    q_i.push_back(ei); q_q.push_back(eq); q_tag.push_back(tag);
    @(posedge clk);
    #1;
    m_acc = m_acc + 40'd8 * m_freq;
    if (p) begin
      m_freq = m_tbl[m_ptr];
      if (m_ptr < 15) m_ptr++;
    end
    if (we) m_tbl[addr] = d;
    cyc++;
    if (q_i.size() == 2) begin
      logic [L*OW-1:0] xi, xq;
      string t;
      xi = q_i.pop_front(); xq = q_q.pop_front(); t = q_tag.pop_front();
      for (int k = 0; k < L; k++) begin
        vectors++;
        if (mix_i[k*OW +: OW] !== xi[k*OW +: OW] || mix_q[k*OW +: OW] !== xq[k*OW +: OW]) begin
          errors++;
          $display("FAIL %s lane %0d cycle %0d: got I=%h Q=%h expected I=%h Q=%h", t, k, cyc,
                   mix_i[k*OW +: OW], mix_q[k*OW +: OW], xi[k*OW +: OW], xq[k*OW +: OW]);
        end
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: registered outputs cleared by reset
    vectors++;
    if (mix_i !== '0 || mix_q !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs: got I=%h Q=%h expected 0", mix_i, mix_q);
    end
    // Load predicts before any strobe: phase stays zero (R1, R7, R8)
    tag = "R1 R7 R8";
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, i, tblv(i));
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 0, '0);
    // Strobes walk the table; R10 wraps via large and negative words
    for (int e = 0; e < 19; e++) begin
      tag = (e >= 16) ? "R6 R3" : "R2 R3 R5";
      if (e == 4) begin
        tag = "R9 R2";
        step(1'b1, 1'b1, 4, 40'h0F_0F0F_0F0F);
      end else begin
        step(1'b1, 1'b0, 0, '0);
      end
      tag = (e >= 16) ? "R6 R4 R10" : "R4 R7 R8 R10";
      for (int j = 0; j < 19; j++) begin
        if (e == 10 && j == 5) step(1'b0, 1'b1, 15, 40'h7A_BCDE_F012);
        else                   step(1'b0, 1'b0, 0, '0);
      end
    end
    step(1'b0, 1'b0, 0, '0);
    summary();
  end

endmodule